// File: doc/BRIEF.md
# Deduplicating Fault Address Store

This block sits beside a memory self-test engine and records the failing word addresses it reports during a test pass. A failing cell is usually flagged on several reads of the same pass. A stuck-at fault, for example, shows up on more than one read element. Each strobed address is therefore compared with every entry already held. Only an address not yet held is written. Entries fill from index 0 upward in arrival order. The comparison is combinational, so a strobe can be accepted on every clock cycle.

The store holds as many entries as there are spare words. The spare words are the top `CAP` addresses of the memory: with the defaults, addresses 58 to 63 are spare and 0 to 57 are normal. The block reports the number of distinct faults held. It also reports how many of those lie inside the spare region, so that repair logic can tell whether its spares are usable. A distinct new fault that arrives when the store is full sets a sticky overflow flag, and that address is not stored. The repair logic reads the entries back through a combinational read port.

Top module: `fault_addr_store`

## Requirements
- R1: While `rst_n` is low, and after it rises, `fault_cnt` is 0, `red_cnt` is 0, `overflow` is 0, and `rd_vld` is 0 for every index.
- R2: A strobe (`fault_vld`=1, `test_done`=0) carrying an address not yet held and arriving with fewer than `CAP` entries held is written at index `fault_cnt`. After that clock edge, `fault_cnt` has risen by 1 and the read port returns that address with `rd_vld`=1 at that index.
- R3: A strobe whose address equals a held entry leaves `fault_cnt`, `red_cnt`, `overflow` and all entries unchanged.
- R4: Strobes on consecutive cycles are each evaluated against all entries held so far. This holds when the same address is strobed twice in a row: the second strobe is a duplicate.
- R5: `red_cnt` counts held entries whose address is at or above `2**ADDR_W - CAP` (58 by default). Address 57 is normal and address 58 is spare.
- R6: A strobe of a new address that arrives with `CAP` entries held sets `overflow` after the edge. It leaves `fault_cnt` at `CAP` and `red_cnt` unchanged, and the address is not stored.
- R7: Once set, `overflow` stays 1 until reset, whatever strobes follow.
- R8: A strobe that arrives with `test_done`=1 is ignored: counts, flag and entries are unchanged.
- R9: The read port is combinational. For `rd_idx` at or above `fault_cnt`, including indices at or above `CAP`, it returns `rd_vld`=0 and `rd_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fault_vld | input | 1 | Failing-address strobe from the test engine |
| fault_addr | input | ADDR_W | Failing word address |
| test_done | input | 1 | Test pass finished; strobes are ignored while high |
| fault_cnt | output | $clog2(CAP+1) | Number of distinct faults held |
| red_cnt | output | $clog2(CAP+1) | Number of held faults inside the spare region |
| overflow | output | 1 | Sticky: a distinct fault arrived while the store was full |
| rd_idx | input | $clog2(CAP) | Entry index to read |
| rd_addr | output | ADDR_W | Address held at `rd_idx` (0 if not valid) |
| rd_vld | output | 1 | Entry at `rd_idx` is valid |

## Verification
The hardest case to bring about is the overflow decision. The store must already hold exactly `CAP` distinct addresses and then receive one more new address, and a duplicate arriving at the same point must be told apart from that new address. The stimulus table fills the store with a mix of repeats sent back to back. It crosses the 57/58 region edge and sends a duplicate while the store is full. Only then does it send a fresh address, and afterwards the entries are read back to show that the fresh address was never written.

// File: rtl/fault_addr_store.sv
module fault_addr_store #(
  parameter int ADDR_W = 6,
  parameter int CAP = 6,
  localparam int CNT_W = $clog2(CAP + 1),
  localparam int IDX_W = $clog2(CAP),
  localparam int RED_BASE = (1 << ADDR_W) - CAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_vld,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              test_done,
  output logic [CNT_W-1:0]  fault_cnt,
  output logic [CNT_W-1:0]  red_cnt,
  output logic              overflow,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld
);

  logic [ADDR_W-1:0] ent [CAP];
  logic [CAP-1:0]    ent_vld;
  logic [CAP-1:0]    match;

  wire take   = fault_vld && !test_done;
  wire hit    = |match;
  wire full   = fault_cnt == CNT_W'(CAP);
  wire wr     = take && !hit && !full;
  wire in_red = fault_addr >= ADDR_W'(RED_BASE);

  for (genvar i = 0; i < CAP; i++) begin : g_ent
    assign match[i] = ent_vld[i] && (ent[i] == fault_addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[i] <= 1'b0;
        ent[i]     <= '0;
      end else if (wr && fault_cnt == CNT_W'(i)) begin
        ent_vld[i] <= 1'b1;
        ent[i]     <= fault_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_cnt <= '0;
      red_cnt   <= '0;
      overflow  <= 1'b0;
    end else begin
      if (wr) begin
        fault_cnt <= fault_cnt + CNT_W'(1);
        if (in_red) red_cnt <= red_cnt + CNT_W'(1);
      end
      if (take && !hit && full) overflow <= 1'b1;
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_vld  = 1'b0;
    for (int i = 0; i < CAP; i++) begin
      if (rd_idx == IDX_W'(i) && ent_vld[i]) begin
        rd_addr = ent[i];
        rd_vld  = 1'b1;
      end
    end
  end

  // R3
  dup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && hit) |=> $stable(fault_cnt) && $stable(red_cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_vld |=> $stable(fault_cnt));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fault_cnt) == CNT_W'(CAP));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> $stable(fault_cnt) && $stable(overflow));

  // R5
  red_le_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    red_cnt <= fault_cnt);

endmodule

// File: tb/tb_fault_addr_store.sv
module tb_fault_addr_store;
  localparam int ADDR_W = 6;
  localparam int CAP = 6;
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int IDX_W = $clog2(CAP);
  localparam int NV = 14;

  logic clk = 0, rst_n = 0;
  logic fault_vld = 0, test_done = 0;
  logic [ADDR_W-1:0] fault_addr = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [CNT_W-1:0] fault_cnt, red_cnt;
  logic overflow, rd_vld;
  logic [ADDR_W-1:0] rd_addr;

  int checks = 0, fails = 0;

  fault_addr_store #(.ADDR_W(ADDR_W), .CAP(CAP)) dut (
    .clk(clk), .rst_n(rst_n), .fault_vld(fault_vld), .fault_addr(fault_addr),
    .test_done(test_done), .fault_cnt(fault_cnt), .red_cnt(red_cnt),
    .overflow(overflow), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_vld(rd_vld));

  always #4 clk = ~clk;

  // {vld, addr[5:0], exp_cnt[2:0], exp_red[2:0], exp_ovf}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 6'd10, 3'd1, 3'd0, 1'b0},  // R2 first entry
    {1'b1, 6'd10, 3'd1, 3'd0, 1'b0},  // R4 back-to-back dup
    {1'b1, 6'd60, 3'd2, 3'd1, 1'b0},  // R5 spare fault
    {1'b1, 6'd10, 3'd2, 3'd1, 1'b0},  // R3
    {1'b1, 6'd60, 3'd2, 3'd1, 1'b0},  // R3
    {1'b0, 6'd0,  3'd2, 3'd1, 1'b0},  // idle
    {1'b1, 6'd0,  3'd3, 3'd1, 1'b0},  // R2 address 0
    {1'b1, 6'd63, 3'd4, 3'd2, 1'b0},  // R5
    {1'b1, 6'd57, 3'd5, 3'd2, 1'b0},  // R5 normal edge
    {1'b1, 6'd58, 3'd6, 3'd3, 1'b0},  // R5 spare edge
    {1'b1, 6'd57, 3'd6, 3'd3, 1'b0},  // R3 dup while full
    {1'b1, 6'd20, 3'd6, 3'd3, 1'b1},  // R6 overflow
    {1'b1, 6'd59, 3'd6, 3'd3, 1'b1},  // R7
    {1'b0, 6'd0,  3'd6, 3'd3, 1'b1}   // R7
  };

  localparam logic [ADDR_W-1:0] ORDER [CAP] = '{6'd10, 6'd60, 6'd0, 6'd63, 6'd57, 6'd58};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic v, input logic [ADDR_W-1:0] a, input logic d);
    @(negedge clk);
    fault_vld = v; fault_addr = a; test_done = d;
    @(negedge clk);
    fault_vld = 0; test_done = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 cnt in reset", fault_cnt, 0);
    chk("R1 ovf in reset", overflow, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cnt", fault_cnt, 0);
    chk("R1 red", red_cnt, 0);
    rd_idx = 0; #1;
    chk("R1 rd_vld", rd_vld, 0);

    for (int k = 0; k < NV; k++) begin
      fault_vld = VEC[k][13]; fault_addr = VEC[k][12:7]; test_done = 0;
      @(negedge clk);
      chk($sformatf("R2/R3/R4 cnt step %0d", k), fault_cnt, int'(VEC[k][6:4]));
      chk($sformatf("R5 red step %0d", k), red_cnt, int'(VEC[k][3:1]));
      chk($sformatf("R6/R7 ovf step %0d", k), overflow, int'(VEC[k][0]));
    end
    fault_vld = 0;

    for (int i = 0; i < CAP; i++) begin
      rd_idx = IDX_W'(i); #1;
      chk($sformatf("R2 order idx %0d", i), rd_addr, ORDER[i]);
      chk($sformatf("R2 vld idx %0d", i), rd_vld, 1);
    end
    for (int i = CAP; i < (1 << IDX_W); i++) begin
      rd_idx = IDX_W'(i); #1;
      chk("R9 out-of-range vld", rd_vld, 0);
      chk("R9 out-of-range addr", rd_addr, 0);
    end

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 cnt after reset", fault_cnt, 0);
    chk("R1 red after reset", red_cnt, 0);
    chk("R7 ovf cleared by reset", overflow, 0);
    rst_n = 1;
    rd_idx = 0; #1;
    chk("R1 entry cleared", rd_vld, 0);

    strobe(1, 6'd5, 1);
    chk("R8 done cnt", fault_cnt, 0);
    rd_idx = 0; #1;
    chk("R8 done entry", rd_vld, 0);
    strobe(1, 6'd61, 0);
    chk("R2 after done low", fault_cnt, 1);
    chk("R5 red after done low", red_cnt, 1);
    rd_idx = 0; #1;
    chk("R2 readback", rd_addr, 61);
    rd_idx = 1; #1;
    chk("R9 idx above cnt", rd_vld, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule